// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat burst on a synchronous pipelined SRAM. A load strobe captures a complete external address. Each later advance strobe steps only the two least significant address bits to the next beat. The upper bits stay at the value that was captured.

A static strap input `ilv_mode` picks the beat order. When it is high, which is also the board default with the pin left open, the order is interleaved: the low bits are the start offset XOR the beat number. When it is low, the order is linear: the low bits are the start offset plus the beat number, modulo four. After the fourth beat the sequence wraps back to the start offset. The block also outputs a beat index so that downstream logic knows where it is in the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_out` and `beat` become zero on that edge.
- R2: When `load` is high at an edge, `addr_out` equals the full `addr_in` (bits 18..0) after that edge, and `beat` becomes 0.
- R3: When `load` and `adv` are both high at the same edge, the load takes effect and the advance is discarded.
- R4: On an advance, `addr_out` bits 18..2 keep their captured values.
- R5: With `ilv_mode`=1, after the k-th advance since the load, `addr_out[1:0]` equals the start offset XOR k. For example, start 2'b10 gives 10, 11, 00, 01.
- R6: With `ilv_mode`=0, after the k-th advance since the load, `addr_out[1:0]` equals (start offset + k) mod 4. For example, start 2'b11 gives 11, 00, 01, 10.
- R7: An advance after the fourth beat returns `addr_out[1:0]` to the start offset, and the four-beat pattern then repeats.
- R8: With neither `load` nor `adv` high at an edge, `addr_out` and `beat` keep their values.
- R9: Each advance without a load increments `beat` by one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture `addr_in` and start a burst |
| adv | input | 1 | Step to the next beat |
| addr_in | input | 19 | External start address |
| ilv_mode | input | 1 | Order strap: 1 = interleaved, 0 = linear |
| addr_out | output | 19 | Registered address of the current beat |
| beat | output | 2 | Registered beat index, 0..3 |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. A load shows up on `addr_out` and `beat` at the next edge. An advance changes only the low bits and the beat index at the next edge. An idle cycle must leave both outputs unchanged across that edge. The bench drives inputs on the falling edge and updates its model at the rising edge. It compares the outputs at the following falling edge, so each comparison falls in the single cycle where the result first becomes due.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned ADDR_W_DEF = 19;
  localparam int unsigned OFS_W_DEF  = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  logic [W-1:0] cnt_q;

  assign cnt_nxt = cnt_q + W'(1);
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] start,
  input  logic [W-1:0] step,
  input  order_e       order,
  output logic [W-1:0] ofs
);
  logic [W-1:0] ilv_ofs;
  logic [W-1:0] lin_ofs;

  for (genvar i = 0; i < W; i++) begin : g_xor
    assign ilv_ofs[i] = start[i] ^ step[i];
  end

  assign lin_ofs = start + step;

  always_comb begin
    if (order == ORD_INTERLEAVE) ofs = ilv_ofs;
    else                         ofs = lin_ofs;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned OFS_W  = OFS_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ilv_mode,
  output logic [ADDR_W-1:0] addr_out,
  output logic [OFS_W-1:0]  beat
);
  localparam int unsigned HI_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0]  start_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFS_W-1:0]  beat_nxt;
  logic [OFS_W-1:0]  ofs_nxt;
  logic              step_en;
  order_e            order;

  assign step_en = adv && !load;
  assign order   = ilv_mode ? ORD_INTERLEAVE : ORD_LINEAR;

  burst_beat_ctr #(.W(OFS_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .inc     (step_en),
    .cnt     (beat),
    .cnt_nxt (beat_nxt)
  );

  burst_offset_map #(.W(OFS_W)) u_map (
    .start (start_q),
    .step  (beat_nxt),
    .order (order),
    .ofs   (ofs_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      addr_q  <= '0;
    end else if (load) begin
      start_q <= addr_in[OFS_W-1:0];
      addr_q  <= addr_in;
    end else if (step_en) begin
      addr_q  <= {addr_q[ADDR_W-1 -: HI_W], ofs_nxt};
    end
  end

  assign addr_out = addr_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned OFS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic              adv,
  input logic [ADDR_W-1:0] addr_in,
  input logic              ilv_mode,
  input logic [ADDR_W-1:0] addr_out,
  input logic [OFS_W-1:0]  beat
);
  logic [OFS_W-1:0] st_q;
  logic [OFS_W-1:0] lin_exp;
  logic             adv_only;

  assign adv_only = adv && !load;
  assign lin_exp  = st_q + beat;

  always_ff @(posedge clk) begin
    if (rst)       st_q <= '0;
    else if (load) st_q <= addr_in[OFS_W-1:0];
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && beat == '0));

  // R2 R3
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr_out == $past(addr_in) && beat == '0));

  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    adv_only |=> addr_out[ADDR_W-1:OFS_W] == $past(addr_out[ADDR_W-1:OFS_W]));

  // R5
  ilv_order_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_only && ilv_mode) |=> addr_out[OFS_W-1:0] == (st_q ^ beat));

  // R6
  lin_order_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_only && !ilv_mode) |=> addr_out[OFS_W-1:0] == lin_exp);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> ($stable(addr_out) && $stable(beat)));

  // R9
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv_only |=> beat == OFS_W'($past(beat) + OFS_W'(1)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .adv      (adv),
  .addr_in  (addr_in),
  .ilv_mode (ilv_mode),
  .addr_out (addr_out),
  .beat     (beat)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic        adv = 1'b0;
  logic [18:0] addr_in = '0;
  logic        ilv_mode = 1'b1;
  logic [18:0] addr_out;
  logic [1:0]  beat;

  int n_tests = 0;
  int n_fail  = 0;
  int m_addr  = 0;
  int m_beat  = 0;
  int m_start = 0;

  always #4 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .addr_in(addr_in), .ilv_mode(ilv_mode),
    .addr_out(addr_out), .beat(beat)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic ld, input logic ad, input int a, input string tag);
    load = ld; adv = ad; addr_in = 19'(a);
    @(posedge clk);
    if (ld) begin
      m_addr = a; m_beat = 0; m_start = a % 4;
    end else if (ad) begin
      m_beat = (m_beat + 1) % 4;
      m_addr = (m_addr & ~3) |
               (ilv_mode ? (m_start ^ m_beat) : ((m_start + m_beat) % 4));
    end
    @(negedge clk);
    check(tag, int'(addr_out), m_addr);
    check(ad && !ld ? "R9" : tag, int'(beat), m_beat);
    if (ad && !ld) check("R4", int'(addr_out) >> 2, m_addr >> 2);
    load = 0; adv = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(addr_out), 0);
    check("R1", int'(beat), 0);
    rst = 1'b0;
    for (int md = 1; md >= 0; md--) begin
      ilv_mode = md[0];
      for (int s = 0; s < 4; s++) begin
        int base = ((12'h5A3 + s * 37 + md * 101) << 2) | s;
        step(1, 0, base, "R2");
        for (int k = 1; k <= 9; k++)
          step(0, 1, 0, k > 4 ? "R7" : (md != 0 ? "R5" : "R6"));
        step(0, 0, 19'h7FFFF, "R8");
        step(0, 0, 0, "R8");
        step(1, 1, (19'h2C00 << 2) | ((s + 1) % 4), "R3");
        step(0, 1, 0, md != 0 ? "R5" : "R6");
      end
    end
    rst = 1'b1;
    step(0, 0, 0, "R1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // reset at the end: model tracks it
  always @(posedge clk) if (rst) begin m_addr = 0; m_beat = 0; m_start = 0; end
endmodule